// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This unit keeps the machine-level trap control state of a simple in-order core and changes it when the pipeline takes an exception or retires a return-from-trap. On an exception, one clock edge saves the faulting PC, the cause code, the trap value and the active privilege level. The same edge moves the interrupt-enable bit into its saved copy and clears the live bit. The unit then asks the fetch stage to continue at the trap vector.

On a trap return, the unit redirects fetch to the saved PC and restores interrupt enable from the saved copy. It also presents the saved privilege level so that the core can return to that level. Trap handler software reads and writes the registers through a CSR port. One of these registers is a scratch word that the handler can swap with its stack pointer.

A two-flop synchronizer releases the reset, so `rst_n` takes effect at once when it falls but is let go in step with the clock.

Top module: `trap_ctrl_unit`

## Requirements
- R1: After reset, `redir_valid` is 0 and `irq_enable` is 0. `restore_priv` reads 3 (machine level). The status word reads 0x1800 and the saved-PC register reads 0.
- R2: An exception loads the saved-PC register (CSR 0x341) with `exc_pc` itself. The same edge loads the cause register (CSR 0x342) with `exc_cause`, which is 0x4 for a misaligned load, and the trap-value register (CSR 0x343) with `exc_tval`.
- R3: An exception copies `cur_priv` into the saved-privilege field, which is status bits 12:11.
- R4: An exception copies the interrupt-enable bit (status bit 3) into the saved-enable bit (status bit 7) and clears the interrupt-enable bit.
- R5: An exception or return sampled at edge N gives `redir_valid` = 1 for exactly the cycle after edge N. `redir_valid` is 0 in every cycle that does not follow an event.
- R6: Writes to the trap-vector register (CSR 0x305) force bits 1:0 to zero. The redirect target on an exception is the trap-vector register value.
- R7: A return redirects to the saved-PC register, loads interrupt enable from the saved-enable bit, and sets the saved-enable bit to 1.
- R8: If `exc_valid` and `mret_valid` are high in the same cycle, only the exception takes effect.
- R9: The scratch register (CSR 0x340) reads back the last value written to it.
- R10: A CSR write in a cycle that has an exception or a return is dropped.
- R11: `restore_priv` always shows the saved-privilege field.
- R12: In the status word (CSR 0x300), only bits 3, 7, 12 and 11 can be written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Take an exception this cycle |
| exc_cause | input | 32 | Cause code of the exception |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_tval | input | 32 | Exception metadata, such as a faulting address |
| cur_priv | input | 2 | Privilege level active at the exception |
| mret_valid | input | 1 | Return-from-trap retires this cycle |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| redir_valid | output | 1 | Fetch redirect request |
| redir_pc | output | 32 | Fetch redirect target |
| irq_enable | output | 1 | Live interrupt-enable bit |
| restore_priv | output | 2 | Privilege level to return to |

## Verification
Register state and the redirect both change at the edge that samples the event. So `redir_valid`, `redir_pc`, `irq_enable` and `restore_priv` are due in the cycle right after that edge, and `redir_valid` must be low again one edge later. CSR reads are combinational and show the updated registers in that same cycle. The bench drives inputs on falling edges and samples one time unit after the rising edge that follows. It holds a CSR address for one time unit before it reads the data.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned CSR_AW = 12;

  localparam logic [CSR_AW-1:0] A_STATUS  = 12'h300;
  localparam logic [CSR_AW-1:0] A_VECTOR  = 12'h305;
  localparam logic [CSR_AW-1:0] A_SCRATCH = 12'h340;
  localparam logic [CSR_AW-1:0] A_EPC     = 12'h341;
  localparam logic [CSR_AW-1:0] A_CAUSE   = 12'h342;
  localparam logic [CSR_AW-1:0] A_TVAL    = 12'h343;

  localparam int unsigned BIT_IE     = 3;
  localparam int unsigned BIT_PIE    = 7;
  localparam int unsigned BIT_PP_LO  = 11;
  localparam int unsigned PRIV_W     = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_USER    = 2'b00,
    PRIV_SUPER   = 2'b01,
    PRIV_RSVD    = 2'b10,
    PRIV_MACHINE = 2'b11
  } priv_e;
endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/trap_event_dec.sv
module trap_event_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_valid,
  input  logic mret_valid,
  input  logic csr_we,
  output logic do_entry,
  output logic do_ret,
  output logic csr_we_ok
);
  always_comb begin
    do_entry  = exc_valid;
    do_ret    = mret_valid && !exc_valid;
    csr_we_ok = csr_we && !exc_valid && !mret_valid;
  end

  // R8
  entry_ret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_entry, do_ret}));

  // R8
  exc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && mret_valid) |-> (do_entry && !do_ret));

  // R10
  csr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid || mret_valid) |-> !csr_we_ok);
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_entry,
  input  logic              do_ret,
  input  logic [XLEN-1:0]   exc_cause,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [XLEN-1:0]   exc_tval,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              ie_o,
  output logic [PRIV_W-1:0] pp_o,
  output logic [XLEN-1:0]   tvec_o,
  output logic [XLEN-1:0]   epc_o
);
  localparam int unsigned ALIGN_W = 2;

  logic              ie_q, ie_d;
  logic              pie_q, pie_d;
  logic [PRIV_W-1:0] pp_q, pp_d;
  logic [XLEN-1:0]   tvec_q, tvec_d;
  logic [XLEN-1:0]   scr_q, scr_d;
  logic [XLEN-1:0]   epc_q, epc_d;
  logic [XLEN-1:0]   cause_q, cause_d;
  logic [XLEN-1:0]   tval_q, tval_d;
  logic [XLEN-1:0]   status_rd;

  always_comb begin
    status_rd = '0;
    status_rd[BIT_IE]  = ie_q;
    status_rd[BIT_PIE] = pie_q;
    status_rd[BIT_PP_LO +: PRIV_W] = pp_q;
  end

  // next state: trap events take the whole register set in one step
  always_comb begin
    ie_d    = ie_q;
    pie_d   = pie_q;
    pp_d    = pp_q;
    tvec_d  = tvec_q;
    scr_d   = scr_q;
    epc_d   = epc_q;
    cause_d = cause_q;
    tval_d  = tval_q;
    if (do_entry) begin
      epc_d   = exc_pc;
      cause_d = exc_cause;
      tval_d  = exc_tval;
      pp_d    = cur_priv;
      pie_d   = ie_q;
      ie_d    = 1'b0;
    end else if (do_ret) begin
      ie_d    = pie_q;
      pie_d   = 1'b1;
    end else if (csr_we) begin
      unique case (csr_addr)
        A_STATUS: begin
          ie_d  = csr_wdata[BIT_IE];
          pie_d = csr_wdata[BIT_PIE];
          pp_d  = csr_wdata[BIT_PP_LO +: PRIV_W];
        end
        A_VECTOR:  tvec_d  = {csr_wdata[XLEN-1:ALIGN_W], {ALIGN_W{1'b0}}};
        A_SCRATCH: scr_d   = csr_wdata;
        A_EPC:     epc_d   = csr_wdata;
        A_CAUSE:   cause_d = csr_wdata;
        A_TVAL:    tval_d  = csr_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      pie_q   <= 1'b0;
      pp_q    <= PRIV_MACHINE;
      tvec_q  <= '0;
      scr_q   <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else begin
      ie_q    <= ie_d;
      pie_q   <= pie_d;
      pp_q    <= pp_d;
      tvec_q  <= tvec_d;
      scr_q   <= scr_d;
      epc_q   <= epc_d;
      cause_q <= cause_d;
      tval_q  <= tval_d;
    end
  end

  always_comb begin
    unique case (csr_addr)
      A_STATUS:  csr_rdata = status_rd;
      A_VECTOR:  csr_rdata = tvec_q;
      A_SCRATCH: csr_rdata = scr_q;
      A_EPC:     csr_rdata = epc_q;
      A_CAUSE:   csr_rdata = cause_q;
      A_TVAL:    csr_rdata = tval_q;
      default:   csr_rdata = '0;
    endcase
  end

  assign ie_o   = ie_q;
  assign pp_o   = pp_q;
  assign tvec_o = tvec_q;
  assign epc_o  = epc_q;

  // R4
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_entry |=> (!ie_q && pie_q == $past(ie_q)));

  // R7
  pie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (pie_q && ie_q == $past(pie_q)));

  // R3
  pp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_entry |=> (pp_q == $past(cur_priv)));

  // R2
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_entry |=> (epc_q == $past(exc_pc) && cause_q == $past(exc_cause)
                  && tval_q == $past(exc_tval)));
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_entry,
  input  logic            do_ret,
  input  logic [XLEN-1:0] tvec,
  input  logic [XLEN-1:0] epc,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc
);
  logic            vld_q, vld_d;
  logic [XLEN-1:0] pc_q, pc_d;

  always_comb begin
    vld_d = do_entry || do_ret;
    pc_d  = pc_q;
    if (do_entry)    pc_d = tvec;
    else if (do_ret) pc_d = epc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      vld_q <= vld_d;
      pc_q  <= pc_d;
    end
  end

  assign redir_valid = vld_q;
  assign redir_pc    = pc_q;

  // R5
  redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_entry || do_ret) |=> redir_valid);

  // R5
  redir_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_entry || do_ret) |=> !redir_valid);

  // R6
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_entry |=> (redir_pc[1:0] == 2'b00));
endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [XLEN-1:0]   exc_cause,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [XLEN-1:0]   exc_tval,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              mret_valid,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic              irq_enable,
  output logic [PRIV_W-1:0] restore_priv
);
  logic            rst_sync_n;
  logic            do_entry, do_ret, we_ok;
  logic [XLEN-1:0] tvec, epc;

  trap_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  trap_event_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .exc_valid  (exc_valid),
    .mret_valid (mret_valid),
    .csr_we     (csr_we),
    .do_entry   (do_entry),
    .do_ret     (do_ret),
    .csr_we_ok  (we_ok)
  );

  trap_csr_regs #(.XLEN(XLEN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .do_entry  (do_entry),
    .do_ret    (do_ret),
    .exc_cause (exc_cause),
    .exc_pc    (exc_pc),
    .exc_tval  (exc_tval),
    .cur_priv  (cur_priv),
    .csr_we    (we_ok),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .ie_o      (irq_enable),
    .pp_o      (restore_priv),
    .tvec_o    (tvec),
    .epc_o     (epc)
  );

  trap_redirect #(.XLEN(XLEN)) u_redir (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .do_entry    (do_entry),
    .do_ret      (do_ret),
    .tvec        (tvec),
    .epc         (epc),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc)
  );

  // R8
  both_events_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exc_valid && mret_valid) |=> (!irq_enable && redir_pc == $past(tvec)));

  // R11
  restore_priv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_valid |=> (restore_priv == $past(cur_priv)));
endmodule

// File: tb/trap_ctrl_unit_tb.sv
module trap_ctrl_unit_tb;
  localparam time CYC = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [31:0] exc_cause = '0;
  logic [31:0] exc_pc = '0;
  logic [31:0] exc_tval = '0;
  logic [1:0]  cur_priv = '0;
  logic        mret_valid = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic        irq_enable;
  logic [1:0]  restore_priv;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  trap_ctrl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_pc(exc_pc), .exc_tval(exc_tval), .cur_priv(cur_priv),
    .mret_valid(mret_valid), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .irq_enable(irq_enable), .restore_priv(restore_priv)
  );

  typedef struct packed {
    logic        exc;
    logic        ret;
    logic [31:0] cause;
    logic [31:0] pc;
    logic [31:0] tval;
    logic [1:0]  priv;
    logic [31:0] x_pc;
    logic        x_ie;
    logic [1:0]  x_rp;
    logic [31:0] x_epc;
    logic [31:0] x_cause;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 32'h4, 32'h80,  32'h1001, 2'd0, 32'h1000_0100, 1'b0, 2'd0, 32'h80,  32'h4},
    '{1'b0, 1'b1, 32'h0, 32'h0,   32'h0,    2'd0, 32'h80,        1'b1, 2'd0, 32'h80,  32'h4},
    '{1'b1, 1'b0, 32'h2, 32'h200, 32'h0,    2'd3, 32'h1000_0100, 1'b0, 2'd3, 32'h200, 32'h2},
    '{1'b1, 1'b1, 32'h5, 32'h300, 32'h55,   2'd1, 32'h1000_0100, 1'b0, 2'd1, 32'h300, 32'h5},
    '{1'b0, 1'b1, 32'h0, 32'h0,   32'h0,    2'd0, 32'h300,       1'b0, 2'd1, 32'h300, 32'h5},
    '{1'b0, 1'b1, 32'h0, 32'h0,   32'h0,    2'd0, 32'h300,       1'b1, 2'd1, 32'h300, 32'h5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    step();
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CYC * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 redir_valid", {31'd0, redir_valid}, 32'd0);
    chk("R1 irq_enable", {31'd0, irq_enable}, 32'd0);
    chk("R11 restore_priv reset", {30'd0, restore_priv}, 32'd3);
    csr_rd(12'h300, rd); chk("R1 status", rd, 32'h1800);
    csr_rd(12'h341, rd); chk("R1 epc", rd, 32'h0);

    // setup: vector with low bits set, ie=1, pp=3
    csr_wr(12'h305, 32'h1000_0103);
    csr_rd(12'h305, rd); chk("R6 vector aligned", rd, 32'h1000_0100);
    csr_wr(12'h300, 32'h0000_1808);

    // table walk: R2 R3 R4 R5 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      exc_valid = TBL[i].exc; mret_valid = TBL[i].ret;
      exc_cause = TBL[i].cause; exc_pc = TBL[i].pc;
      exc_tval = TBL[i].tval; cur_priv = TBL[i].priv;
      step();
      chk($sformatf("R5 row%0d redir_valid", i), {31'd0, redir_valid}, 32'd1);
      chk($sformatf("R6/R7/R8 row%0d redir_pc", i), redir_pc, TBL[i].x_pc);
      chk($sformatf("R4/R7 row%0d irq_enable", i), {31'd0, irq_enable}, {31'd0, TBL[i].x_ie});
      chk($sformatf("R3/R11 row%0d restore_priv", i), {30'd0, restore_priv}, {30'd0, TBL[i].x_rp});
      @(negedge clk);
      exc_valid = 1'b0; mret_valid = 1'b0;
      csr_rd(12'h341, rd); chk($sformatf("R2 row%0d epc", i), rd, TBL[i].x_epc);
      csr_rd(12'h342, rd); chk($sformatf("R2 row%0d cause", i), rd, TBL[i].x_cause);
    end

    // R5: pulse lasts one cycle
    step();
    chk("R5 redir drops", {31'd0, redir_valid}, 32'd0);

    // R2 trap value from row 3
    csr_rd(12'h343, rd); chk("R2 tval", rd, 32'h55);

    // R7 saved-enable set after return
    csr_rd(12'h300, rd); chk("R7 pie set", rd & 32'h80, 32'h80);

    // R9 scratch
    csr_wr(12'h340, 32'hCAFE_F00D);
    csr_rd(12'h340, rd); chk("R9 scratch", rd, 32'hCAFE_F00D);

    // R12 status mask
    csr_wr(12'h300, 32'hFFFF_FFFF);
    csr_rd(12'h300, rd); chk("R12 status mask", rd, 32'h1888);
    chk("R12 ie written", {31'd0, irq_enable}, 32'd1);

    // R10: CSR write dropped in an exception cycle
    @(negedge clk);
    exc_valid = 1'b1; exc_pc = 32'h444; exc_cause = 32'h4; exc_tval = 32'h447;
    cur_priv = 2'd0;
    csr_we = 1'b1; csr_addr = 12'h340; csr_wdata = 32'h1234;
    step();
    @(negedge clk);
    exc_valid = 1'b0; csr_we = 1'b0;
    csr_rd(12'h340, rd); chk("R10 scratch kept", rd, 32'hCAFE_F00D);
    csr_rd(12'h341, rd); chk("R10 epc from exception", rd, 32'h444);
    csr_rd(12'h300, rd); chk("R4 pie took ie", rd, 32'h0080);

    finish_run();
  end
endmodule